// File: doc/BRIEF.md
# SD Single-Lane Read Data Receiver

This block takes in read data blocks that a memory card sends on its first data line in one-bit bus mode. A start pulse latches three settings: the block size, the block count and a timeout limit. The block then looks for each block's zero start bit and shifts in the data bytes, most significant bit first. After the data it takes the sixteen CRC bits and the closing one bit, and checks both. It repeats this for the number of blocks that was programmed. Each group of four received bytes goes to a downstream FIFO as one 32-bit word, with the first byte in the low lane.

The line is sampled only in cycles where the bit-enable strobe is high, so the card clock divider can stay outside the block. A timeout watches how long the block waits for each start bit. A 5-bit sticky status register collects the result of the transfer, and a one-cycle clear strobe empties it. The downstream FIFO does not hold back the card's bit stream. If a word is offered in a cycle where the FIFO is not ready, the block reports an overrun and abandons the transfer.

Top module: `sd_dat_rx`

## Requirements
- R1: After reset, status is 0, busy is 0 and outValid is 0.
- R2: dat0 is sampled only in cycles where bitEn is 1. While waiting, ones on sampled bits and any value in cycles with bitEn at 0 are ignored. The first sampled 0 is the start bit of a block.
- R3: Data bits arrive most significant bit first. Byte k of a block is placed at word bits [8*(k mod 4)+7 : 8*(k mod 4)]. outValid is high for exactly one cycle, in the cycle after the sample that completes the fourth byte of a word or the last byte of a block. A partial last word has zeros in its unfilled upper lanes.
- R4: blockSizeM1, latched at start, gives the number of data bytes per block minus one.
- R5: blockCountM1, latched at start, gives the number of blocks minus one. Status bit 0 (transfer done) is set only after the good end bit of the last block, and busy then returns to 0.
- R6: The 16 bits after the data are a CRC sent most significant bit first. The CRC uses polynomial 0x1021, starts at 0 and covers the block's data bits. On a mismatch the block sets status bits 3 and 1, skips the remaining blocks, does not set bit 0, and drops busy.
- R7: A 0 in the end-bit position is handled the same way as a CRC mismatch: status bits 3 and 1 are set and the transfer ends.
- R8: While waiting for a start bit, the timeout counts clock cycles from 0 and restarts for every block. When no start bit has been seen after timeoutLimit+1 cycles, the block sets status bits 2 and 1 and ends the transfer.
- R9: If outValid is high in a cycle where outReady is 0, the block sets status bits 4 and 1 and ends the transfer. It offers no further words.
- R10: A clrStatus pulse clears all status bits. A start pulse while busy is ignored, and the settings present on the inputs at that time are not latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (accepted when idle) |
| blockSizeM1 | input | 12 | Bytes per block minus one |
| blockCountM1 | input | 16 | Blocks per transfer minus one |
| timeoutLimit | input | 32 | Start-bit wait limit in clock cycles |
| bitEn | input | 1 | Sample strobe for dat0 |
| dat0 | input | 1 | Serial data line |
| clrStatus | input | 1 | Clears the sticky status |
| outData | output | 32 | Packed data word |
| outValid | output | 1 | One-cycle word strobe |
| outReady | input | 1 | Downstream FIFO can accept a word |
| busy | output | 1 | Transfer in progress |
| status | output | 5 | Bit 0: done. Bit 1: any error. Bit 2: timeout. Bit 3: CRC or end-bit error. Bit 4: overrun |

## Verification
The bench drives the opposite of each bit in the cycles where the strobe is low. A receiver that samples without the strobe therefore corrupts every word. It also sends a 6-byte block to check that the second word is zero-padded; packing that carries stale lanes across would leave old bytes in the upper lanes. A three-block transfer checks that the done flag stays clear until the last block. Its gaps between blocks add up to more than the limit while each gap stays under it, so a design that never restarts the timeout would report a spurious timeout. Further cases cover a corrupted CRC, a zero end bit, an early start pulse with changed settings, and a FIFO that is not ready. In each of these a faulty design either lets later blocks through, latches the wrong size, or keeps sending words after the overrun.

// File: rtl/sd_dat_rx_pkg.sv
package sd_dat_rx_pkg;
  localparam int WORD_BYTES = 4;
  localparam int LANE_W = $clog2(WORD_BYTES);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DATA,
    ST_CRC,
    ST_END
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              initBlock;
    logic              dataBit;
    logic              byteEnd;
    logic              wordEnd;
    logic [LANE_W-1:0] lane;
    logic              crcBit;
  } dpCtl_t;
endpackage

// File: rtl/sd_dat_rx_ctrl.sv
module sd_dat_rx_ctrl
  import sd_dat_rx_pkg::*;
#(
  parameter int BLK_W = 12,
  parameter int CNT_W = 16,
  parameter int TO_W  = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [BLK_W-1:0] blockSizeM1,
  input  logic [CNT_W-1:0] blockCountM1,
  input  logic [TO_W-1:0]  timeoutLimit,
  input  logic             bitEn,
  input  logic             dat0,
  input  logic             clrStatus,
  input  logic             outValid,
  input  logic             outReady,
  input  logic             crcMatch,
  output dpCtl_t           ctl,
  output logic             busy,
  output logic [4:0]       status
);
  localparam int CRC_BITS = 16;
  localparam int CRC_CW = $clog2(CRC_BITS);

  rxState_t          state;
  logic [2:0]        bitCnt;
  logic [BLK_W-1:0]  byteCnt;
  logic [CNT_W-1:0]  blkCnt;
  logic [CRC_CW-1:0] crcCnt;
  logic [TO_W-1:0]   toCnt;
  logic [BLK_W-1:0]  cfgSize;
  logic [CNT_W-1:0]  cfgCount;
  logic [TO_W-1:0]   cfgTo;
  logic              lastByte;
  logic              overrun;

  assign lastByte = (byteCnt == cfgSize);
  assign overrun  = outValid && !outReady;
  assign busy     = (state != ST_IDLE);

  always_comb begin
    ctl           = '0;
    ctl.initBlock = (state == ST_WAIT) && bitEn && !dat0;
    ctl.dataBit   = (state == ST_DATA) && bitEn;
    ctl.byteEnd   = ctl.dataBit && (bitCnt == 3'd7);
    ctl.lane      = byteCnt[LANE_W-1:0];
    ctl.wordEnd   = ctl.byteEnd && ((ctl.lane == LANE_W'(WORD_BYTES-1)) || lastByte);
    ctl.crcBit    = (state == ST_CRC) && bitEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      byteCnt  <= '0;
      blkCnt   <= '0;
      crcCnt   <= '0;
      toCnt    <= '0;
      cfgSize  <= '0;
      cfgCount <= '0;
      cfgTo    <= '0;
      status   <= '0;
    end else begin
      if (clrStatus) status <= '0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            cfgSize  <= blockSizeM1;
            cfgCount <= blockCountM1;
            cfgTo    <= timeoutLimit;
            blkCnt   <= '0;
            toCnt    <= '0;
            state    <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (ctl.initBlock) begin
            bitCnt  <= '0;
            byteCnt <= '0;
            state   <= ST_DATA;
          end else if (toCnt == cfgTo) begin
            status[2] <= 1'b1;
            status[1] <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            toCnt <= toCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (ctl.dataBit) begin
            bitCnt <= bitCnt + 1'b1;
            if (ctl.byteEnd) begin
              if (lastByte) begin
                crcCnt <= '0;
                state  <= ST_CRC;
              end else begin
                byteCnt <= byteCnt + 1'b1;
              end
            end
          end
        end
        ST_CRC: begin
          if (ctl.crcBit) begin
            crcCnt <= crcCnt + 1'b1;
            if (crcCnt == CRC_CW'(CRC_BITS-1)) state <= ST_END;
          end
        end
        ST_END: begin
          if (bitEn) begin
            if (!dat0 || !crcMatch) begin
              status[3] <= 1'b1;
              status[1] <= 1'b1;
              state     <= ST_IDLE;
            end else if (blkCnt == cfgCount) begin
              status[0] <= 1'b1;
              state     <= ST_IDLE;
            end else begin
              blkCnt <= blkCnt + 1'b1;
              toCnt  <= '0;
              state  <= ST_WAIT;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (overrun && busy) begin
        status[4] <= 1'b1;
        status[1] <= 1'b1;
        state     <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/sd_dat_rx_dp.sv
module sd_dat_rx_dp
  import sd_dat_rx_pkg::*;
#(
  parameter int WORD_W = 8 * WORD_BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dat0,
  input  dpCtl_t            ctl,
  output logic [WORD_W-1:0] outData,
  output logic              outValid,
  output logic              crcMatch
);
  localparam logic [15:0] CRC_POLY = 16'h1021;

  logic [7:0]        byteReg;
  logic [7:0]        newByte;
  logic [WORD_W-1:0] wordReg;
  logic [WORD_W-1:0] wordNext;
  logic [15:0]       crcCalc;
  logic [15:0]       crcRecv;
  logic              crcFb;

  assign newByte  = {byteReg[6:0], dat0};
  assign crcFb    = crcCalc[15] ^ dat0;
  assign crcMatch = (crcCalc == crcRecv);

  // writing lane 0 clears the upper lanes so a short last word is zero padded
  for (genvar g = 0; g < WORD_BYTES; g++) begin : gLane
    if (g == 0) begin : gLow
      assign wordNext[7:0] = (ctl.lane == '0) ? newByte : wordReg[7:0];
    end else begin : gHigh
      assign wordNext[8*g +: 8] = (ctl.lane == LANE_W'(g)) ? newByte :
                                  (ctl.lane == '0) ? 8'h00 : wordReg[8*g +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteReg  <= '0;
      wordReg  <= '0;
      crcCalc  <= '0;
      crcRecv  <= '0;
      outData  <= '0;
      outValid <= 1'b0;
    end else begin
      if (ctl.initBlock) begin
        crcCalc <= '0;
        crcRecv <= '0;
      end
      if (ctl.dataBit) begin
        byteReg <= newByte;
        crcCalc <= {crcCalc[14:0], 1'b0} ^ (crcFb ? CRC_POLY : 16'h0000);
      end
      if (ctl.byteEnd) wordReg <= wordNext;
      if (ctl.crcBit) crcRecv <= {crcRecv[14:0], dat0};
      outValid <= ctl.wordEnd;
      if (ctl.wordEnd) outData <= wordNext;
    end
  end
endmodule

// File: rtl/sd_dat_rx.sv
module sd_dat_rx
  import sd_dat_rx_pkg::*;
#(
  parameter int BLK_W = 12,
  parameter int CNT_W = 16,
  parameter int TO_W  = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [BLK_W-1:0] blockSizeM1,
  input  logic [CNT_W-1:0] blockCountM1,
  input  logic [TO_W-1:0]  timeoutLimit,
  input  logic             bitEn,
  input  logic             dat0,
  input  logic             clrStatus,
  output logic [31:0]      outData,
  output logic             outValid,
  input  logic             outReady,
  output logic             busy,
  output logic [4:0]       status
);
  dpCtl_t ctl;
  logic   crcMatch;

  sd_dat_rx_ctrl #(.BLK_W(BLK_W), .CNT_W(CNT_W), .TO_W(TO_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .blockSizeM1(blockSizeM1),
    .blockCountM1(blockCountM1), .timeoutLimit(timeoutLimit), .bitEn(bitEn),
    .dat0(dat0), .clrStatus(clrStatus), .outValid(outValid), .outReady(outReady),
    .crcMatch(crcMatch), .ctl(ctl), .busy(busy), .status(status)
  );

  sd_dat_rx_dp #(.WORD_W(32)) u_dp (
    .clk(clk), .rstN(rstN), .dat0(dat0), .ctl(ctl),
    .outData(outData), .outValid(outValid), .crcMatch(crcMatch)
  );
endmodule

// File: rtl/sd_dat_rx_chk.sv
module sd_dat_rx_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic [4:0] status,
  input logic       outValid,
  input logic       outReady,
  input logic       clrStatus
);
  AST_RESET_STATE: assert property (@(posedge clk) $rose(rstN) |-> (status == 5'd0 && !busy && !outValid)); // R1
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN) outValid |=> !outValid); // R3
  AST_NO_WORD_IDLE: assert property (@(posedge clk) disable iff (!rstN) !busy |-> !outValid); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN) $rose(status[0]) |-> !busy); // R5
  AST_CRC_ERR: assert property (@(posedge clk) disable iff (!rstN) status[3] |-> status[1]); // R6
  AST_TIMEOUT_ERR: assert property (@(posedge clk) disable iff (!rstN) status[2] |-> status[1]); // R8
  AST_OVERRUN: assert property (@(posedge clk) disable iff (!rstN) (outValid && !outReady) |=> (status[4] && !busy)); // R9
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rstN) (clrStatus && !busy) |=> (status == 5'd0)); // R10
endmodule

bind sd_dat_rx sd_dat_rx_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .status(status),
  .outValid(outValid), .outReady(outReady), .clrStatus(clrStatus)
);

// File: tb/sd_dat_rx_tb.sv
module sd_dat_rx_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [11:0] blockSizeM1 = '0;
  logic [15:0] blockCountM1 = '0;
  logic [31:0] timeoutLimit = '0;
  logic        bitEn = 1'b0;
  logic        dat0 = 1'b1;
  logic        clrStatus = 1'b0;
  logic        outReady = 1'b1;
  logic [31:0] outData;
  logic        outValid;
  logic        busy;
  logic [4:0]  status;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [31:0] expQ[$];

  always #10 clk = ~clk;

  sd_dat_rx u_dut (
    .clk(clk), .rstN(rstN), .start(start), .blockSizeM1(blockSizeM1),
    .blockCountM1(blockCountM1), .timeoutLimit(timeoutLimit), .bitEn(bitEn),
    .dat0(dat0), .clrStatus(clrStatus), .outData(outData), .outValid(outValid),
    .outReady(outReady), .busy(busy), .status(status)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard for data words (R3, R4)
  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9 unexpected word actual=%h expected=none", outData);
      end else begin
        chk("R3 word", outData, expQ.pop_front());
      end
    end
  end

  function automatic logic [15:0] crcAdd(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
  endfunction

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // bit strobe every other cycle; opposite value driven while strobe is low (R2)
  task automatic sendBit(input logic b);
    @(negedge clk); dat0 = b; bitEn = 1'b1;
    @(negedge clk); bitEn = 1'b0; dat0 = ~b;
  endtask

  task automatic idleBits(input int n);
    for (int i = 0; i < n; i++) sendBit(1'b1);
  endtask

  task automatic startXfer(input int sizeM1, input int countM1, input int lim);
    @(negedge clk);
    blockSizeM1 = 12'(sizeM1); blockCountM1 = 16'(countM1); timeoutLimit = 32'(lim);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic clearStat();
    @(negedge clk); clrStatus = 1'b1;
    @(negedge clk); clrStatus = 1'b0;
    @(negedge clk);
    chk("R10 clear", {27'd0, status}, 32'd0);
  endtask

  task automatic sendBlock(input int n, input int seed, input bit expect_, input bit badCrc, input bit badEnd);
    logic [7:0]  b;
    logic [15:0] crc;
    logic [31:0] word;
    crc = 16'h0000;
    word = '0;
    sendBit(1'b0);
    for (int k = 0; k < n; k++) begin
      b = 8'((seed * 37 + k * 13 + 5) & 255);
      if (k % 4 == 0) word = '0;
      word[8*(k%4) +: 8] = b;
      if (expect_ && (k % 4 == 3 || k == n - 1)) expQ.push_back(word);
      for (int i = 7; i >= 0; i--) begin
        crc = crcAdd(crc, b[i]);
        sendBit(b[i]);
      end
    end
    if (badCrc) crc = crc ^ 16'h0001;
    for (int i = 15; i >= 0; i--) sendBit(crc[i]);
    sendBit(badEnd ? 1'b0 : 1'b1);
  endtask

  initial begin
    clocks(3);
    chk("R1 status", {27'd0, status}, 32'd0);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 valid", {31'd0, outValid}, 32'd0);
    rstN = 1'b1;
    clocks(2);

    // single 8-byte block, early start with other settings ignored (R2 R4 R10)
    startXfer(7, 0, 1000);
    blockSizeM1 = 12'd2; blockCountM1 = 16'd5;
    start = 1'b1; @(negedge clk); start = 1'b0;
    idleBits(3);
    sendBlock(8, 1, 1'b1, 1'b0, 1'b0);
    clocks(3);
    chk("R5 single done", {27'd0, status}, 32'd1);
    chk("R5 idle", {31'd0, busy}, 32'd0);
    chk("R4 words", expQ.size(), 0);
    clearStat();

    // 6-byte block: zero padded last word (R3)
    startXfer(5, 0, 1000);
    sendBlock(6, 2, 1'b1, 1'b0, 1'b0);
    clocks(3);
    chk("R3 partial done", {27'd0, status}, 32'd1);
    chk("R3 words", expQ.size(), 0);
    clearStat();

    // three 4-byte blocks, gaps below limit each, total above (R5 R8)
    startXfer(3, 2, 20);
    sendBlock(4, 3, 1'b1, 1'b0, 1'b0);
    idleBits(8);
    sendBlock(4, 4, 1'b1, 1'b0, 1'b0);
    clocks(1);
    chk("R5 not done early", {27'd0, status}, 32'd0);
    chk("R8 still busy", {31'd0, busy}, 32'd1);
    idleBits(8);
    sendBlock(4, 5, 1'b1, 1'b0, 1'b0);
    clocks(3);
    chk("R5 multi done", {27'd0, status}, 32'd1);
    chk("R5 words", expQ.size(), 0);
    clearStat();

    // bad CRC on first of two blocks (R6)
    startXfer(3, 1, 1000);
    sendBlock(4, 6, 1'b1, 1'b1, 1'b0);
    clocks(3);
    chk("R6 crc status", {27'd0, status}, 32'h0A);
    chk("R6 idle", {31'd0, busy}, 32'd0);
    sendBlock(4, 7, 1'b0, 1'b0, 1'b0);
    clocks(3);
    chk("R6 no more blocks", expQ.size(), 0);
    clearStat();

    // zero end bit (R7)
    startXfer(3, 0, 1000);
    sendBlock(4, 8, 1'b1, 1'b0, 1'b1);
    clocks(3);
    chk("R7 end bit status", {27'd0, status}, 32'h0A);
    clearStat();

    // timeout (R8)
    startXfer(3, 0, 20);
    clocks(10);
    chk("R8 before limit", {27'd0, status}, 32'd0);
    chk("R8 busy", {31'd0, busy}, 32'd1);
    clocks(20);
    chk("R8 timeout status", {27'd0, status}, 32'h06);
    chk("R8 idle", {31'd0, busy}, 32'd0);
    clearStat();

    // overrun (R9)
    outReady = 1'b0;
    startXfer(7, 0, 1000);
    sendBlock(8, 9, 1'b0, 1'b0, 1'b0);
    clocks(3);
    chk("R9 overrun status", {27'd0, status}, 32'h12);
    chk("R9 idle", {31'd0, busy}, 32'd0);
    outReady = 1'b1;
    sendBlock(8, 10, 1'b0, 1'b0, 1'b0);
    clocks(3);
    chk("R9 no words", expQ.size(), 0);
    clearStat();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule